// File: doc/BRIEF.md
# Word Load/Store Access Unit

This unit carries out single-word loads and stores for a byte-addressed memory that keeps words in big-endian byte order. A request consists of a command (idle, load or store), a base register value, a signed byte offset and, for stores, the register word to be written. The unit sign-extends the offset, adds it to the base to form the byte address, and checks that the address falls on a word boundary. For a legal access it drives a synchronous word-indexed memory port in the same cycle.

A store writes all byte lanes of one word. The most significant register byte goes to the lowest-addressed lane. A load gets its word from the memory one cycle later. The unit restores register byte order and presents the result with a one-cycle valid strobe, which acts as the register write-back enable. A request whose address is not a multiple of four never reaches memory. Instead a fault strobe pulses in the cycle where the response would have appeared, and no write-back happens.

Top module: `lsu_word_unit`

## Requirements
- R1: For a load or store, the byte address is `req_base` plus the offset, and `mem_idx` carries that address with its two low bits removed, in the request cycle (for example, base 1000 and offset 12 give index 253).
- R2: The offset is a two's-complement byte count. When its bit 15 is set it lowers the address: base 0x50 with offset 0xFFF0 gives address 0x40. Address arithmetic wraps modulo 2^32.
- R3: When the byte address has either of its two low bits set, `mem_we` and `mem_re` stay low in the request cycle. `fault` is then high in the following cycle only.
- R4: A misaligned load produces no `ld_valid` pulse.
- R5: An aligned load or store drives `mem_be` to all ones (4'hF). An aligned store raises `mem_we` and an aligned load raises `mem_re`.
- R6: For a store, memory lane k (`mem_wdata[8k+7:8k]`, where lane 0 is the lowest byte address) carries register bits [31-8k:24-8k], so lane 0 holds bits 31..24.
- R7: An aligned load raises `ld_valid` for one cycle, the cycle after the request. `ld_data` then holds the register word rebuilt from lanes of `mem_rdata` with the same mapping as R6. Back-to-back loads each get their own response.
- R8: For the idle command (0) or the unused code 3, `mem_we`, `mem_re` and `mem_be` are zero, and no `ld_valid` or `fault` follows.
- R9: While `rst_n` is low, `ld_valid` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_cmd | input | 2 | 0 idle, 1 load, 2 store, 3 treated as idle |
| req_base | input | 32 | Base register value |
| req_offs | input | 16 | Signed byte offset |
| req_wdata | input | 32 | Register word to store |
| mem_idx | output | 30 | Word index to memory |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data in memory lane order |
| mem_rdata | input | 32 | Read data in memory lane order, one cycle after `mem_re` |
| ld_valid | output | 1 | Load result valid, write-back enable |
| ld_data | output | 32 | Loaded word in register byte order |
| fault | output | 1 | Misaligned access strobe |

## Verification
The bench builds the unit with its default widths: 32-bit addresses and data and a 16-bit offset. These widths make the sign-extension boundary reachable, because an offset with bit 15 set must subtract from the base. They also make the top-of-address-space wrap reachable (base 4, offset -8 lands at index 0x3FFFFFFF). Four byte lanes are enough to show the full lane reversal with a distinct value in every byte. They also allow every misaligned case to be tested as a nonzero address remainder of 1, 2 or 3.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    LSU_IDLE  = 2'd0,
    LSU_LOAD  = 2'd1,
    LSU_STORE = 2'd2
  } lsu_cmd_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int OFFS_W  = 16,
  parameter int ALIGN_W = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFFS_W-1:0] offs_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misal_o
);

  localparam int EXT_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] offs_ext;

  always_comb begin
    offs_ext = {{EXT_W{offs_i[OFFS_W-1]}}, offs_i};
    ea_o     = base_i + offs_ext;
    misal_o  = |ea_o[ALIGN_W-1:0];
  end

endmodule

// File: rtl/lsu_lane_swap.sv
module lsu_lane_swap #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int LANES = DATA_W / lsu_pkg::BYTE_W;
  localparam int BW    = lsu_pkg::BYTE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign dout[BW*k +: BW] = din[DATA_W-BW*(k+1) +: BW];
  end

endmodule

// File: rtl/lsu_resp.sv
module lsu_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic load_go,
  input  logic bad_req,
  output logic ld_valid_o,
  output logic fault_o
);

  logic valid_q, valid_d;
  logic fault_q, fault_d;
  logic upd_en;

  always_comb begin
    valid_d = load_go;
    fault_d = bad_req;
    upd_en  = load_go | bad_req | valid_q | fault_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      fault_q <= fault_d;
    end
  end

  assign ld_valid_o = valid_q;
  assign fault_o    = fault_q;

endmodule

// File: rtl/lsu_word_unit.sv
module lsu_word_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0]                             req_cmd,
  input  logic [ADDR_W-1:0]                      req_base,
  input  logic [OFFS_W-1:0]                      req_offs,
  input  logic [DATA_W-1:0]                      req_wdata,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     mem_idx,
  output logic                                   mem_re,
  output logic                                   mem_we,
  output logic [DATA_W/8-1:0]                    mem_be,
  output logic [DATA_W-1:0]                      mem_wdata,
  input  logic [DATA_W-1:0]                      mem_rdata,
  output logic                                   ld_valid,
  output logic [DATA_W-1:0]                      ld_data,
  output logic                                   fault
);

  localparam int LANES   = DATA_W / BYTE_W;
  localparam int ALIGN_W = $clog2(LANES);

  lsu_cmd_e          cmd;
  logic [ADDR_W-1:0] ea;
  logic              misal;
  logic              acc;
  logic              go;
  logic [DATA_W-1:0] rd_swapped;

  always_comb begin
    case (req_cmd)
      2'd1:    cmd = LSU_LOAD;
      2'd2:    cmd = LSU_STORE;
      default: cmd = LSU_IDLE;
    endcase
  end

  lsu_addr_gen #(
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W),
    .ALIGN_W(ALIGN_W)
  ) u_agen (
    .base_i (req_base),
    .offs_i (req_offs),
    .ea_o   (ea),
    .misal_o(misal)
  );

  always_comb begin
    acc     = (cmd != LSU_IDLE);
    go      = acc && !misal;
    mem_idx = ea[ADDR_W-1:ALIGN_W];
    mem_re  = go && (cmd == LSU_LOAD);
    mem_we  = go && (cmd == LSU_STORE);
    mem_be  = go ? {LANES{1'b1}} : {LANES{1'b0}};
  end

  lsu_lane_swap #(.DATA_W(DATA_W)) u_st_swap (
    .din (req_wdata),
    .dout(mem_wdata)
  );

  lsu_lane_swap #(.DATA_W(DATA_W)) u_ld_swap (
    .din (mem_rdata),
    .dout(rd_swapped)
  );

  lsu_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_go   (mem_re),
    .bad_req   (acc && misal),
    .ld_valid_o(ld_valid),
    .fault_o   (fault)
  );

  assign ld_data = ld_valid ? rd_swapped : '0;

endmodule

// File: rtl/lsu_word_unit_chk.sv
module lsu_word_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16,
  parameter int DATA_W = 32
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [1:0]                         req_cmd,
  input logic [ADDR_W-1:0]                  req_base,
  input logic [OFFS_W-1:0]                  req_offs,
  input logic [DATA_W-1:0]                  req_wdata,
  input logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_idx,
  input logic                               mem_re,
  input logic                               mem_we,
  input logic [DATA_W/8-1:0]                mem_be,
  input logic [DATA_W-1:0]                  mem_wdata,
  input logic                               ld_valid,
  input logic                               fault
);

  localparam int AL = $clog2(DATA_W/8);

  logic [ADDR_W-1:0] c_ea;
  logic              c_acc;
  logic              c_bad;

  always_comb begin
    c_ea  = req_base + ADDR_W'($signed(req_offs));
    c_acc = (req_cmd == 2'd1) || (req_cmd == 2'd2);
    c_bad = c_acc && (c_ea[AL-1:0] != '0);
  end

  assert_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_idx == c_ea[ADDR_W-1:AL]));

  assert_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_bad |-> (!mem_we && !mem_re));

  assert_fault_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_bad |=> fault);

  assert_no_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !ld_valid);

  assert_full_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_be == '1));

  assert_lane0_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[7:0] == req_wdata[DATA_W-1 -: 8]));

  assert_load_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ld_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !c_acc |=> (!ld_valid && !fault));

endmodule

bind lsu_word_unit lsu_word_unit_chk #(
  .ADDR_W(ADDR_W),
  .OFFS_W(OFFS_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_cmd  (req_cmd),
  .req_base (req_base),
  .req_offs (req_offs),
  .req_wdata(req_wdata),
  .mem_idx  (mem_idx),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .mem_be   (mem_be),
  .mem_wdata(mem_wdata),
  .ld_valid (ld_valid),
  .fault    (fault)
);

// File: tb/test_lsu_word_unit.sv
`timescale 1ns/1ps
module test_lsu_word_unit;

  logic        clk;
  logic        rst_n;
  logic [1:0]  req_cmd;
  logic [31:0] req_base;
  logic [15:0] req_offs;
  logic [31:0] req_wdata;
  logic [29:0] mem_idx;
  logic        mem_re;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        fault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [33:0] expq[$];
  logic [33:0] ent;
  logic [31:0] bmem [16];

  lsu_word_unit i_lsu_word_unit (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_base(req_base),
    .req_offs(req_offs), .req_wdata(req_wdata), .mem_idx(mem_idx),
    .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_data(ld_data), .fault(fault)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // synchronous memory model, lanes as seen on the port
  always @(posedge clk) begin
    if (mem_we) begin
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) bmem[mem_idx[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end
    if (mem_re) mem_rdata <= bmem[mem_idx[3:0]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // kind: 0 nothing, 1 load data, 2 fault
  task automatic req(input logic [1:0] c, input logic [31:0] b, input logic [15:0] o,
                     input logic [31:0] wd, input int kind, input logic [31:0] ed,
                     input logic [29:0] eidx);
    @(negedge clk);
    req_cmd = c; req_base = b; req_offs = o; req_wdata = wd;
    expq.push_back({2'(kind), ed});
    #1;
    if (kind == 2) begin
      chk(!mem_we && !mem_re, "R3 misaligned must not access", {30'd0, mem_we, mem_re}, 32'd0);
    end else if (c == 2'd1 || c == 2'd2) begin
      chk(mem_idx == eidx, "R1/R2 word index", {2'd0, mem_idx}, {2'd0, eidx});
      chk(mem_be == 4'hF, "R5 byte enables", {28'd0, mem_be}, 32'hF);
      chk(mem_we == (c == 2'd2) && mem_re == (c == 2'd1), "R5 strobe",
          {30'd0, mem_we, mem_re}, {30'd0, c == 2'd2, c == 2'd1});
      if (c == 2'd2)
        chk(mem_wdata == {wd[7:0], wd[15:8], wd[23:16], wd[31:24]}, "R6 store lanes",
            mem_wdata, {wd[7:0], wd[15:8], wd[23:16], wd[31:24]});
    end else begin
      chk(!mem_we && !mem_re && mem_be == 4'h0, "R8 idle quiet",
          {26'd0, mem_be, mem_we, mem_re}, 32'd0);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      ent = (expq.size() != 0) ? expq.pop_front() : 34'd0;
      chk(ld_valid == (ent[33:32] == 2'd1), "R7/R4 ld_valid", {31'd0, ld_valid},
          {31'd0, ent[33:32] == 2'd1});
      chk(fault == (ent[33:32] == 2'd2), "R3 fault pulse", {31'd0, fault},
          {31'd0, ent[33:32] == 2'd2});
      if (ent[33:32] == 2'd1)
        chk(ld_data == ent[31:0], "R7 load data", ld_data, ent[31:0]);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_cmd = 2'd1; req_base = 32'd1000; req_offs = 16'd12; req_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!ld_valid && !fault, "R9 reset state", {30'd0, ld_valid, fault}, 32'd0);
    @(negedge clk);
    req_cmd = 2'd0;
    rst_n = 1'b1;

    // store at 1000+12 -> index 253 (bmem[13])
    req(2'd2, 32'd1000, 16'd12, 32'h11223344, 0, 0, 30'd253);
    // store at 0x40 -> index 16 (bmem[0])
    req(2'd2, 32'h40, 16'h0000, 32'hA5B6C7D8, 0, 0, 30'd16);
    chk(bmem[13][7:0] == 8'h11, "R6 lane0 holds msb", {24'd0, bmem[13][7:0]}, 32'h11);
    // back-to-back loads, second with negative offset
    req(2'd1, 32'd1000, 16'd12, 0, 1, 32'h11223344, 30'd253);
    req(2'd1, 32'h50, 16'hFFF0, 0, 1, 32'hA5B6C7D8, 30'd16);
    // misaligned store must not write
    req(2'd2, 32'd1000, 16'd13, 32'hDEADBEEF, 2, 0, 0);
    req(2'd1, 32'd1000, 16'd12, 0, 1, 32'h11223344, 30'd253);
    // misaligned loads (remainders 2 and 3)
    req(2'd1, 32'd2, 16'd0, 0, 2, 0, 0);
    req(2'd1, 32'd0, 16'hFFFF, 0, 2, 0, 0);
    // idle codes
    req(2'd0, 32'd1000, 16'd12, 0, 0, 0, 0);
    req(2'd3, 32'd1000, 16'd12, 0, 0, 0, 0);
    // wrap at top of address space: 4 + (-8) = 0xFFFFFFFC
    req(2'd2, 32'd4, 16'hFFF8, 32'h0BADF00D, 0, 0, 30'h3FFFFFFF);
    req(2'd1, 32'd4, 16'hFFF8, 0, 1, 32'h0BADF00D, 30'h3FFFFFFF);
    req(2'd0, 32'd0, 16'd0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule